// File: doc/BRIEF.md
# GPIO Port Interrupt Trigger and Flag Unit

This block watches the synchronized levels of one GPIO port (32 pins by default) and latches a per-pin interrupt flag whenever a pin's configured trigger condition is met. Each pin's mode comes from configuration bits that are held in the port register file and arrive here as plain inputs:

- an interrupt-select bit, which makes the pin an interrupt source;
- a mask bit, which blocks the request but not the flag;
- a trigger-kind bit, which selects level or edge;
- a polarity bit, which selects high/rising or low/falling;
- a both-edges bit, which in edge mode makes either transition count.

Software reads the flag vector directly. It clears flags by presenting a write-one-to-clear mask together with a write strobe. The block drives one combined interrupt request for the whole port. Any pin whose flag is set, which is selected as an interrupt source and which is not masked raises that request.

Edges are found by comparing each pin's current level with the level seen at the previous clock edge. Just after reset there is no earlier level to compare with, so no edge is reported at the first clock edge out of reset. If a trigger condition and a clear of the same pin occur at the same clock edge, the trigger wins. A pin that is still at its active level therefore keeps its flag set through a clear.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is asserted, and at the first sampling point after reset, every flag bit is 0 and the interrupt request is 0.
- R2: A pin whose interrupt-select bit is 0 never sets its flag, whatever its level or transitions.
- R3: In level mode (trigger-kind bit 0), the pin's flag is set at every clock edge where the pin is at its active level. Polarity 1 makes high the active level and polarity 0 makes low the active level.
- R4: In edge mode (trigger-kind bit 1) with the both-edges bit at 0, polarity 1 sets the flag at the first clock edge where the pin is 1 after it was 0 at the previous clock edge. Polarity 0 sets the flag on the opposite transition, from 1 to 0. A pin held steady after its edge does not set the flag again.
- R5: In edge mode with the both-edges bit at 1, both transitions set the flag and the polarity bit has no effect. In level mode the both-edges bit has no effect.
- R6: At a clock edge where the clear strobe is 1, each flag bit whose clear-mask bit is 1 becomes 0 unless R7 applies. Flag bits whose clear-mask bit is 0 are kept. With no trigger and no clear, a flag holds its value.
- R7: When a trigger condition and a clear of the same pin occur at the same clock edge, the flag is 1 after that edge. A level-mode pin still at its active level therefore stays flagged through a clear.
- R8: The interrupt request is 1 exactly when at least one pin has its flag set, its interrupt-select bit at 1 and its mask bit at 0. The request follows mask changes in the same cycle. The mask does not stop the flag from being set.
- R9: No edge is reported at the first clock edge after reset is released, even if a pin is already high or low at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | PINS | Synchronized pin levels |
| cfg_int | input | PINS | Interrupt-select bit per pin (1 = interrupt source) |
| cfg_mask | input | PINS | Mask bit per pin (1 = request blocked) |
| cfg_trig | input | PINS | Trigger kind per pin (0 = level, 1 = edge) |
| cfg_pol | input | PINS | Polarity per pin (1 = high or rising, 0 = low or falling) |
| cfg_dual | input | PINS | Both-edges enable per pin (effective in edge mode only) |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | PINS | Write-one-to-clear mask, used while clr_we is 1 |
| flags_o | output | PINS | Interrupt flag vector |
| irq_o | output | 1 | Combined port interrupt request |

## Verification
A stale previous-level register would show up on flags_o one edge late. It would appear as a missed transition, or as a spurious rise just after reset. A flag register that mishandles a clear that collides with a trigger would show a level-active pin dropping to 0 for exactly one cycle. The reference model is compared with the flag vector and the request every cycle, so any such divergence is reported in the cycle after the clock edge that caused it. A wrong combine of mask and select would be visible on irq_o in the same cycle that the configuration changes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        KIND_OFF    = 3'd0,
        KIND_LVL_LO = 3'd1,
        KIND_LVL_HI = 3'd2,
        KIND_FALL   = 3'd3,
        KIND_RISE   = 3'd4,
        KIND_BOTH   = 3'd5
    } trig_kind_t;

    function automatic trig_kind_t decode_kind(logic sel, logic trig, logic pol, logic dual);
        trig_kind_t k;
        if (!sel)
            k = KIND_OFF;
        else if (!trig)
            k = pol ? KIND_LVL_HI : KIND_LVL_LO;
        else if (dual)
            k = KIND_BOTH;
        else
            k = pol ? KIND_RISE : KIND_FALL;
        return k;
    endfunction

endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] rise_o,
    output logic [PINS-1:0] fall_o
);
    typedef struct packed {
        logic [PINS-1:0] prev;
        logic            seeded;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = pin_level;
        st_d.seeded = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = {PINS{st_q.seeded}} &  pin_level & ~st_q.prev;
    assign fall_o = {PINS{st_q.seeded}} & ~pin_level &  st_q.prev;

endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0] cfg_int,
    input  logic [PINS-1:0] cfg_trig,
    input  logic [PINS-1:0] cfg_pol,
    input  logic [PINS-1:0] cfg_dual,
    input  logic [PINS-1:0] pin_level,
    input  logic [PINS-1:0] rise_i,
    input  logic [PINS-1:0] fall_i,
    output logic [PINS-1:0] event_o
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        trig_kind_t kind;
        always_comb begin
            kind = decode_kind(cfg_int[p], cfg_trig[p], cfg_pol[p], cfg_dual[p]);
            unique case (kind)
                KIND_LVL_LO: event_o[p] = ~pin_level[p];
                KIND_LVL_HI: event_o[p] =  pin_level[p];
                KIND_FALL:   event_o[p] =  fall_i[p];
                KIND_RISE:   event_o[p] =  rise_i[p];
                KIND_BOTH:   event_o[p] =  rise_i[p] | fall_i[p];
                default:     event_o[p] =  1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_flag.sv
module gpio_irq_flag #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] event_i,
    input  logic            clr_we,
    input  logic [PINS-1:0] clr_mask,
    input  logic [PINS-1:0] cfg_int,
    input  logic [PINS-1:0] cfg_mask,
    output logic [PINS-1:0] flags_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [PINS-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [PINS-1:0] wipe;

    always_comb begin
        wipe       = clr_we ? clr_mask : '0;
        st_d       = st_q;
        st_d.flags = event_i | (st_q.flags & ~wipe);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & cfg_int & ~cfg_mask);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_level,
    input  logic [PINS-1:0] cfg_int,
    input  logic [PINS-1:0] cfg_mask,
    input  logic [PINS-1:0] cfg_trig,
    input  logic [PINS-1:0] cfg_pol,
    input  logic [PINS-1:0] cfg_dual,
    input  logic            clr_we,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] flags_o,
    output logic            irq_o
);
    logic [PINS-1:0] rise, fall, hit;

    gpio_irq_edge #(.PINS(PINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    gpio_irq_trig #(.PINS(PINS)) u_trig (
        .cfg_int   (cfg_int),
        .cfg_trig  (cfg_trig),
        .cfg_pol   (cfg_pol),
        .cfg_dual  (cfg_dual),
        .pin_level (pin_level),
        .rise_i    (rise),
        .fall_i    (fall),
        .event_o   (hit)
    );

    gpio_irq_flag #(.PINS(PINS)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (hit),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .cfg_int  (cfg_int),
        .cfg_mask (cfg_mask),
        .flags_o  (flags_o),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int PINS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PINS-1:0] pin_level,
    input logic [PINS-1:0] cfg_int,
    input logic [PINS-1:0] cfg_mask,
    input logic [PINS-1:0] cfg_trig,
    input logic [PINS-1:0] cfg_pol,
    input logic            clr_we,
    input logic [PINS-1:0] clr_mask,
    input logic [PINS-1:0] flags_o,
    input logic            irq_o
);
    logic [PINS-1:0] lvl_active;
    logic [PINS-1:0] clr_eff;

    assign lvl_active = cfg_int & ~cfg_trig & ~(cfg_pol ^ pin_level);
    assign clr_eff    = clr_we ? clr_mask : '0;

    // R2: an unselected, unflagged pin stays unflagged
    assert_no_unselected_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_o & ~$past(cfg_int) & ~$past(flags_o)) == '0));

    // R3 and R7: an active level always leaves the flag set, clear or not
    assert_level_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_o & $past(lvl_active)) == $past(lvl_active)));

    // R6: a cleared bit of an unselected pin is 0 afterwards
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_o & $past(clr_eff & ~cfg_int)) == '0));

    // R8: a request needs at least one flag
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o != '0));

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .cfg_int   (cfg_int),
    .cfg_mask  (cfg_mask),
    .cfg_trig  (cfg_trig),
    .cfg_pol   (cfg_pol),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .flags_o   (flags_o),
    .irq_o     (irq_o)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
    localparam int PINS   = 32;
    localparam int PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PINS-1:0] pin_level, cfg_int, cfg_mask, cfg_trig, cfg_pol, cfg_dual, clr_mask;
    logic            clr_we;
    logic [PINS-1:0] flags_o;
    logic            irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    gpio_irq_unit #(.PINS(PINS)) uut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
        .cfg_int(cfg_int), .cfg_mask(cfg_mask), .cfg_trig(cfg_trig),
        .cfg_pol(cfg_pol), .cfg_dual(cfg_dual), .clr_we(clr_we),
        .clr_mask(clr_mask), .flags_o(flags_o), .irq_o(irq_o)
    );

    // behavioural reference model
    bit m_flag [PINS];
    bit m_prev [PINS];
    bit m_seeded;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_seeded = 0;
            for (int i = 0; i < PINS; i++) begin
                m_flag[i] = 0;
                m_prev[i] = 0;
            end
        end else begin
            for (int i = 0; i < PINS; i++) begin
                bit hit;
                bit up, down;
                up   = m_seeded && pin_level[i] && !m_prev[i];
                down = m_seeded && !pin_level[i] && m_prev[i];
                hit  = 0;
                if (cfg_int[i]) begin
                    if (!cfg_trig[i])      hit = (pin_level[i] == cfg_pol[i]);
                    else if (cfg_dual[i])  hit = up || down;
                    else                   hit = cfg_pol[i] ? up : down;
                end
                if (clr_we && clr_mask[i]) m_flag[i] = 0;
                if (hit) m_flag[i] = 1;
                m_prev[i] = pin_level[i];
            end
            m_seeded = 1;
        end
    end

    function automatic logic [PINS-1:0] model_flags();
        logic [PINS-1:0] v;
        for (int i = 0; i < PINS; i++) v[i] = m_flag[i];
        return v;
    endfunction

    task automatic check(string tag, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #(PERIOD/4);
        if (rst_n === 1'b1 && !done) begin
            logic [PINS-1:0] mf;
            mf = model_flags();
            check("model flags R2 R3 R4 R5 R6 R7 R9", flags_o, mf);
            check("model irq R8", {31'b0, irq_o}, {31'b0, |(mf & cfg_int & ~cfg_mask)});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clr_we = 0; clr_mask = '0;
        cfg_int = '0; cfg_mask = '0; cfg_trig = '0; cfg_pol = '0; cfg_dual = '0;
        // pin 0: rising edge, already high during reset (R9)
        pin_level = 32'h0000_0001;
        cfg_int[0] = 1; cfg_trig[0] = 1; cfg_pol[0] = 1;
        #1;
        check("R1 flags in reset", flags_o, '0);
        check("R1 irq in reset", {31'b0, irq_o}, '0);
        tick(); tick();
        rst_n = 1;
        tick();
        check("R1 flags after reset", flags_o, '0);
        tick();
        check("R9 no edge at first clock", flags_o & 32'h1, '0);

        // R3: level high on pin 1, level low on pin 2
        cfg_int[1] = 1; cfg_pol[1] = 1; pin_level[1] = 0;
        tick();
        check("R3 inactive high level", flags_o & 32'h2, '0);
        pin_level[1] = 1;
        cfg_int[2] = 1; cfg_pol[2] = 0; pin_level[2] = 0;
        tick();
        check("R3 high level sets", flags_o & 32'h6, 32'h6);

        // R7: clear while level still active
        clr_we = 1; clr_mask = 32'h2;
        tick();
        clr_we = 0;
        check("R7 clear loses to active level", flags_o & 32'h2, 32'h2);
        pin_level[1] = 0; clr_we = 1; clr_mask = 32'h2;
        tick();
        clr_we = 0;
        check("R6 clear takes effect", flags_o & 32'h2, '0);
        check("R6 uncleared bit kept", flags_o & 32'h4, 32'h4);

        // R2: unselected pin ignores level
        cfg_pol[3] = 1; pin_level[3] = 1;
        tick();
        check("R2 unselected pin", flags_o & 32'h8, '0);

        // R4: rising on pin 4, falling on pin 5
        cfg_int[4] = 1; cfg_trig[4] = 1; cfg_pol[4] = 1; pin_level[4] = 0;
        cfg_int[5] = 1; cfg_trig[5] = 1; cfg_pol[5] = 0; pin_level[5] = 1;
        tick();
        check("R4 no edge yet", flags_o & 32'h30, '0);
        pin_level[4] = 1;
        tick();
        check("R4 rise sets", flags_o & 32'h30, 32'h10);
        clr_we = 1; clr_mask = 32'h10;
        tick();
        clr_we = 0;
        tick();
        check("R4 held level no retrigger", flags_o & 32'h10, '0);
        pin_level[5] = 0;
        tick();
        check("R4 fall sets", flags_o & 32'h20, 32'h20);

        // R5: both edges on pin 6, dual ignored in level mode on pin 7
        cfg_int[6] = 1; cfg_trig[6] = 1; cfg_dual[6] = 1; cfg_pol[6] = 1; pin_level[6] = 1;
        cfg_int[7] = 1; cfg_dual[7] = 1; cfg_pol[7] = 1; pin_level[7] = 0;
        tick();
        check("R5 dual rise", flags_o & 32'h40, 32'h40);
        clr_we = 1; clr_mask = 32'h40;
        tick();
        clr_we = 0;
        check("R5 dual cleared", flags_o & 32'h40, '0);
        pin_level[6] = 0;
        tick();
        check("R5 dual fall", flags_o & 32'h40, 32'h40);
        check("R5 dual no effect in level mode", flags_o & 32'h80, '0);

        // R8: mask blocks request, not flag
        cfg_int = '0;
        clr_we = 1; clr_mask = '1;
        tick();
        clr_we = 0;
        check("R6 clear all", flags_o, '0);
        check("R8 no request", {31'b0, irq_o}, '0);
        cfg_int[8] = 1; cfg_mask[8] = 1; cfg_pol[8] = 1; pin_level[8] = 1;
        tick();
        check("R8 masked pin flags", flags_o & 32'h100, 32'h100);
        check("R8 masked no request", {31'b0, irq_o}, '0);
        cfg_mask[8] = 0;
        #1;
        check("R8 unmask raises request", {31'b0, irq_o}, 32'h1);
        tick();
        tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule